// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Formatter

This block turns a stream of decoded stereo sample words (up to 24 bits per channel) into a three-wire serial audio link: a bit clock, a word clock and a data line. It runs on a system clock that is a fixed multiple of the frame rate (128, 256, 384 or 512 times) and divides that clock down to a bit clock of 64 periods per frame, so every channel owns a 32-bit slot. A 2-bit format input picks one of four framings inside the slot. These are 16-bit right-justified, 24-bit right-justified, 24-bit left-justified and I2S.

The upstream subframe decoder presents the current left and right words along with a parity-error flag for each channel, a flag that marks the stream as non-PCM and a receiver error flag. A new pair and the format select are captured once per frame, at the bit-clock fall that opens the left slot. For PCM streams, a word flagged with a parity error is replaced by the previous sample of the same channel. Non-PCM words pass through untouched. While the receiver reports an error, the data line is forced low.

Top module: `sa_serial_formatter`

## Requirements
- R1: With `fmt_sel` = 00, the upper 16 bits of each word (bits 23..8) appear MSB first at slot positions 16..31. All other positions in the slot are low, and `lrck` is high during the left slot (positions 0..31 of the frame) and low during the right slot (positions 32..63).
- R2: With `fmt_sel` = 01, the full 24-bit word appears MSB first at slot positions 8..31. Other positions are low, and `lrck` is high for the left slot.
- R3: With `fmt_sel` = 10, the 24-bit word appears MSB first at slot positions 0..23. Other positions are low, and `lrck` is high for the left slot.
- R4: With `fmt_sel` = 11, the 24-bit word appears MSB first at slot positions 1..24. Other positions are low, and `lrck` is low for the left slot and high for the right slot.
- R5: `bck` has a period of 2*(`clk_ratio`+1) system clocks. It is low for the first half of each period and high for the second half. There are 64 periods per frame, and `lrck` and `sdata` change only when `bck` falls. Slot position equals the count of `bck` falls since the frame started.
- R6: When `non_pcm` is 0 and a channel's parity flag is high at the frame capture point, that channel re-sends the word it sent in the previous frame.
- R7: When `non_pcm` is 1, a word whose parity flag is high is sent as presented.
- R8: `rx_error` is sampled at every `bck` fall. While the sampled value is 1, `sdata` is low.
- R9: While `rst_n` is low (synchronous, active low), `bck`, `lrck` and `sdata` are low. The first frame after reset carries zero words in the 16-bit right-justified framing.
- R10: Words and `fmt_sel` are captured only at the `bck` fall that begins position 0 of a frame. Changes at any other time do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, a multiple of the frame rate |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Output framing select |
| clk_ratio | input | 2 | System clock ratio: 0=128x, 1=256x, 2=384x, 3=512x frame rate |
| left_word | input | 24 | Left sample, two's complement, MSB at bit 23 |
| right_word | input | 24 | Right sample, two's complement, MSB at bit 23 |
| left_perr | input | 1 | Parity error on the left word |
| right_perr | input | 1 | Parity error on the right word |
| non_pcm | input | 1 | Stream carries non-PCM payload |
| rx_error | input | 1 | Receiver reports an error; mutes the data line |
| bck | output | 1 | Bit clock, 64 periods per frame |
| lrck | output | 1 | Word clock at the frame rate |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The frame capture and the mute sampling both fall on the same `bck` edge at the start of a frame. The bench raises `rx_error` while a parity-flagged PCM word is being captured. It then checks that the concealed word is stored but not shown while the mute holds, and that the stored word appears once the mute drops. The bench's behavioural model advances the frame, the concealment and the mute on every system clock and compares all three outputs on every cycle. It also changes the inputs in the middle of frames to show that they are ignored until the next capture point.

// File: rtl/sa_fmt_pkg.sv
// Shared types for the serial audio output formatter.
package sa_fmt_pkg;
    typedef enum logic [1:0] {
        FMT_RJ16 = 2'b00,
        FMT_RJ24 = 2'b01,
        FMT_LJ24 = 2'b10,
        FMT_I2S  = 2'b11
    } sa_fmt_e;
endpackage

// File: rtl/sa_bit_timer.sv
// Bit clock divider and frame position counter.
// Assumes the system clock runs at 2*(ratio+1) cycles per bit clock.
// The bit clock is low for the first half of each period and high for the second.
// fall_tick marks the system clock edge on which the bit clock falls.
module sa_bit_timer #(
    parameter int SLOT_W = 32,
    parameter int DIV_W  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [DIV_W-1:0]                     ratio,
    output logic                                 bck_hi,
    output logic [$clog2(2*SLOT_W)-1:0]          bit_pos,
    output logic                                 fall_tick,
    output logic                                 frame_tick,
    output logic                                 live
);
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int PH_W    = DIV_W + 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] half;
    logic [PH_W-1:0] last;

    // Half period and last phase index for the selected ratio.
    always_comb begin
        half = PH_W'(ratio) + PH_W'(1);
        last = (half << 1) - PH_W'(1);
    end

    assign bck_hi     = (phase >= half);
    assign fall_tick  = (phase >= last);
    assign frame_tick = fall_tick && (bit_pos == POS_W'(FRAME_W - 1));

    // Advance the phase counter and step the slot position on each bit clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_pos <= '0;
            live    <= 1'b0;
        end else begin
            live <= 1'b1;
            if (fall_tick) begin
                phase   <= '0;
                bit_pos <= bit_pos + POS_W'(1);
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    a_r5_pos_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(bit_pos));
    a_r5_pos_steps: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> (bit_pos == POS_W'($past(bit_pos) + POS_W'(1))));
endmodule

// File: rtl/sa_word_hold.sv
// Captures the sample pair and the format once per frame, and conceals PCM parity errors.
// Also samples the receiver error flag on every bit clock fall to form the mute.
// Assumes frame_tick is a one-cycle strobe at the fall that opens the left slot.
module sa_word_hold #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              fall_tick,
    input  logic [1:0]        fmt_in,
    input  logic [WORD_W-1:0] in_l,
    input  logic [WORD_W-1:0] in_r,
    input  logic              perr_l,
    input  logic              perr_r,
    input  logic              non_pcm,
    input  logic              rx_error,
    output logic [WORD_W-1:0] word_l,
    output logic [WORD_W-1:0] word_r,
    output logic [1:0]        fmt_q,
    output logic              mute_q
);
    localparam int NCH = 2;

    logic [WORD_W-1:0] in_w [NCH];
    logic [WORD_W-1:0] held [NCH];
    logic [NCH-1:0]    perr;

    assign in_w[0] = in_l;
    assign in_w[1] = in_r;
    assign perr    = {perr_r, perr_l};
    assign word_l  = held[0];
    assign word_r  = held[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Take a fresh word at the frame start unless a PCM parity error asks to repeat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[ch] <= '0;
            end else if (frame_tick && !(perr[ch] && !non_pcm)) begin
                held[ch] <= in_w[ch];
            end
        end

        a_r6_conceal: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_tick && perr[ch] && !non_pcm) |=> $stable(held[ch]));
        a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_tick && non_pcm) |=> (held[ch] == $past(in_w[ch])));
        a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_tick |=> $stable(held[ch]));
    end

    // Latch the framing once per frame so a frame never mixes formats.
    always_ff @(posedge clk) begin
        if (!rst_n)          fmt_q <= 2'b00;
        else if (frame_tick) fmt_q <= fmt_in;
    end

    // Sample the receiver error on each bit clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)         mute_q <= 1'b0;
        else if (fall_tick) mute_q <= rx_error;
    end

    a_r8_mute_sample: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> (mute_q == $past(rx_error)));
    a_r10_fmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(fmt_q));
endmodule

// File: rtl/sa_slot_shaper.sv
// Maps the frame position, format and held words to the word clock and data bit.
// Purely combinational. Assumes SLOT_W > WORD_W >= NARROW_W.
module sa_slot_shaper
    import sa_fmt_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16,
    parameter int SLOT_W   = 32
) (
    input  logic [1:0]                   fmt,
    input  logic [$clog2(2*SLOT_W)-1:0]  bit_pos,
    input  logic [WORD_W-1:0]            word_l,
    input  logic [WORD_W-1:0]            word_r,
    output logic                         lrck_raw,
    output logic                         data_raw
);
    localparam int POS_W  = $clog2(2 * SLOT_W);
    localparam int SLOT_B = POS_W - 1;

    logic              right_slot;
    logic [SLOT_B-1:0] k;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shifted;
    int                start;
    int                len;
    int                off;

    assign right_slot = bit_pos[POS_W-1];
    assign k          = bit_pos[SLOT_B-1:0];
    assign word       = right_slot ? word_r : word_l;

    // Word clock polarity: I2S is low for the left slot, the justified framings are high.
    always_comb begin
        if (sa_fmt_e'(fmt) == FMT_I2S) lrck_raw = right_slot;
        else                           lrck_raw = ~right_slot;
    end

    // Pick the data window inside the slot for the active framing.
    always_comb begin
        case (sa_fmt_e'(fmt))
            FMT_RJ16: begin start = SLOT_W - NARROW_W; len = NARROW_W; end
            FMT_RJ24: begin start = SLOT_W - WORD_W;   len = WORD_W;   end
            FMT_LJ24: begin start = 0;                 len = WORD_W;   end
            default:  begin start = 1;                 len = WORD_W;   end
        endcase
    end

    // Emit the word bit MSB first inside the window and low outside it.
    always_comb begin
        off      = int'(k) - start;
        shifted  = word << off;
        data_raw = (off >= 0 && off < len) ? shifted[WORD_W-1] : 1'b0;
    end
endmodule

// File: rtl/sa_serial_formatter.sv
// Top of the serial audio output formatter.
// Derives the bit and word clocks from the system clock, holds one sample pair per
// frame with parity concealment, and frames the data in the selected format.
// Assumes a system clock of 128/256/384/512 times the frame rate, chosen by clk_ratio.
module sa_serial_formatter #(
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16,
    parameter int SLOT_W   = 32,
    parameter int DIV_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic [DIV_W-1:0]  clk_ratio,
    input  logic [WORD_W-1:0] left_word,
    input  logic [WORD_W-1:0] right_word,
    input  logic              left_perr,
    input  logic              right_perr,
    input  logic              non_pcm,
    input  logic              rx_error,
    output logic              bck,
    output logic              lrck,
    output logic              sdata
);
    localparam int POS_W = $clog2(2 * SLOT_W);

    logic              bck_hi;
    logic [POS_W-1:0]  bit_pos;
    logic              fall_tick;
    logic              frame_tick;
    logic              live;
    logic [WORD_W-1:0] word_l;
    logic [WORD_W-1:0] word_r;
    logic [1:0]        fmt_q;
    logic              mute_q;
    logic              lrck_raw;
    logic              data_raw;

    sa_bit_timer #(.SLOT_W(SLOT_W), .DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio      (clk_ratio),
        .bck_hi     (bck_hi),
        .bit_pos    (bit_pos),
        .fall_tick  (fall_tick),
        .frame_tick (frame_tick),
        .live       (live)
    );

    sa_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .fall_tick  (fall_tick),
        .fmt_in     (fmt_sel),
        .in_l       (left_word),
        .in_r       (right_word),
        .perr_l     (left_perr),
        .perr_r     (right_perr),
        .non_pcm    (non_pcm),
        .rx_error   (rx_error),
        .word_l     (word_l),
        .word_r     (word_r),
        .fmt_q      (fmt_q),
        .mute_q     (mute_q)
    );

    sa_slot_shaper #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .SLOT_W(SLOT_W)) u_shape (
        .fmt      (fmt_q),
        .bit_pos  (bit_pos),
        .word_l   (word_l),
        .word_r   (word_r),
        .lrck_raw (lrck_raw),
        .data_raw (data_raw)
    );

    // Outputs stay low until the first edge after reset, and the data line is muted on error.
    assign bck   = live & bck_hi;
    assign lrck  = live & lrck_raw;
    assign sdata = live & ~mute_q & data_raw;

    a_r5_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(live) && !$stable(lrck)) |-> $fell(bck));
    a_r5_sdata_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(live) && !$stable(sdata)) |-> $fell(bck));
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q |-> !sdata);
endmodule

// File: tb/sa_serial_formatter_test.sv
module sa_serial_formatter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  clk_ratio = 2'b00;
    logic [23:0] left_word = '0;
    logic [23:0] right_word = '0;
    logic        left_perr = 1'b0;
    logic        right_perr = 1'b0;
    logic        non_pcm = 1'b0;
    logic        rx_error = 1'b0;
    logic        bck, lrck, sdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural reference state.
    int m_phase = 0, m_pos = 0, m_fmt = 0;
    bit m_live = 0, m_mute = 0;
    bit [23:0] m_w [2];
    bit m_conc [2];
    bit m_np_err [2];
    bit m_first = 1;

    always #4 clk = ~clk;

    sa_serial_formatter uut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .clk_ratio(clk_ratio),
        .left_word(left_word), .right_word(right_word),
        .left_perr(left_perr), .right_perr(right_perr),
        .non_pcm(non_pcm), .rx_error(rx_error),
        .bck(bck), .lrck(lrck), .sdata(sdata)
    );

    // Reference model: frame counter, per-frame capture with concealment, mute sampling.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_pos = 0; m_live = 0; m_mute = 0; m_fmt = 0;
            m_w[0] = '0; m_w[1] = '0; m_first = 1;
            m_conc[0] = 0; m_conc[1] = 0; m_np_err[0] = 0; m_np_err[1] = 0;
        end else begin
            m_live = 1;
            if (m_phase >= 2 * (int'(clk_ratio) + 1) - 1) begin
                m_phase = 0;
                m_mute = rx_error;
                if (m_pos == 63) begin
                    m_pos = 0;
                    m_first = 0;
                    m_fmt = int'(fmt_sel);
                    m_conc[0] = left_perr && !non_pcm;
                    m_conc[1] = right_perr && !non_pcm;
                    m_np_err[0] = left_perr && non_pcm;
                    m_np_err[1] = right_perr && non_pcm;
                    if (!m_conc[0]) m_w[0] = left_word;
                    if (!m_conc[1]) m_w[1] = right_word;
                end else begin
                    m_pos++;
                end
            end else begin
                m_phase++;
            end
        end
    end

    function automatic string fmt_tag(int f);
        case (f)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Compare all outputs against the model once per cycle, away from the clock edge.
    always @(negedge clk) begin
        int  half, k, ch, st, ln;
        bit  e_bck, e_lrck, e_dat;
        string t;
        #1;
        half = int'(clk_ratio) + 1;
        k    = m_pos % 32;
        ch   = (m_pos >= 32) ? 1 : 0;
        case (m_fmt)
            0: begin st = 16; ln = 16; end
            1: begin st = 8;  ln = 24; end
            2: begin st = 0;  ln = 24; end
            default: begin st = 1; ln = 24; end
        endcase
        e_bck  = m_live && (m_phase >= half);
        e_lrck = m_live && ((m_fmt == 3) ? (ch == 1) : (ch == 0));
        e_dat  = m_live && !m_mute && (k >= st) && (k < st + ln) && m_w[ch][23 - (k - st)];
        if (!m_live) t = "R9";
        else if (m_mute) t = "R8";
        else if (m_conc[ch]) t = "R6";
        else if (m_np_err[ch]) t = "R7";
        else if (m_first) t = "R9";
        else t = fmt_tag(m_fmt);
        if ((ch == 0 && left_word != m_w[0]) || (ch == 1 && right_word != m_w[1]))
            t = {t, " R10"};
        checks++;
        if (bck !== e_bck) begin
            errors++;
            $display("FAIL R5 bck at cycle %0d: actual %b expected %b", cycles, bck, e_bck);
        end
        checks++;
        if (lrck !== e_lrck) begin
            errors++;
            $display("FAIL %s lrck at cycle %0d: actual %b expected %b", m_live ? fmt_tag(m_fmt) : "R9", cycles, lrck, e_lrck);
        end
        checks++;
        if (sdata !== e_dat) begin
            errors++;
            $display("FAIL %s sdata at cycle %0d pos %0d: actual %b expected %b", t, cycles, m_pos, sdata, e_dat);
        end
    end

    // Run for a number of system clocks, refreshing the words at odd moments (R10).
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % 53 == 7) begin
                left_word  = 24'($urandom);
                right_word = 24'($urandom);
            end
        end
    endtask

    task automatic do_reset(input logic [1:0] ratio);
        @(negedge clk);
        rst_n = 1'b0;
        clk_ratio = ratio;
        run(6);
        rst_n = 1'b1;
    endtask

    initial begin
        m_w[0] = '0; m_w[1] = '0;
        left_word = 24'h800001; right_word = 24'h7ffffe;
        run(6);
        rst_n = 1'b1;
        // R9 zero first frame, then R1 with fresh words.
        fmt_sel = 2'b00; run(128 * 4);
        fmt_sel = 2'b01; run(128 * 3);     // R2
        fmt_sel = 2'b10; run(128 * 3);     // R3
        fmt_sel = 2'b11; run(128 * 3);     // R4
        // R6: PCM concealment on each channel.
        non_pcm = 0; left_perr = 1; run(128 * 2);
        left_perr = 0; right_perr = 1; run(128 * 2);
        right_perr = 0;
        // R7: non-PCM words pass through with parity flags set.
        non_pcm = 1; left_perr = 1; right_perr = 1; run(128 * 2);
        left_perr = 0; right_perr = 0; non_pcm = 0;
        // R8 together with R6: mute across a concealing capture, then release.
        rx_error = 1; left_perr = 1; run(128 * 2 + 40);
        left_perr = 0; rx_error = 0; run(128 * 2);
        // Other clock ratios after a reset (R5, R9).
        do_reset(2'b01); fmt_sel = 2'b10; run(256 * 3);
        do_reset(2'b10); fmt_sel = 2'b11; run(384 * 3);
        do_reset(2'b11); fmt_sel = 2'b01; run(512 * 2);
        rx_error = 1; run(300); rx_error = 0; run(512 * 2);
        // Reset mid-frame (R9).
        @(negedge clk); rst_n = 1'b0; run(5); rst_n = 1'b1;
        fmt_sel = 2'b00; run(512 * 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule